// File: doc/BRIEF.md
# Derived-Clock Gating and Power-Down Controller

This block produces a family of derived clock outputs from one fast input clock and decides, per output, whether that output runs, stops low or floats. The outputs fall into seven rate groups: host (three outputs), memory (eight switchable outputs and one free-running output), hub (three outputs), peripheral bus (six switchable outputs and one free-running output), interrupt-controller (two outputs), 48 MHz (two outputs) and reference (one output). In this model every output is a divided copy of the input clock `clk_i`. One `clk_i` cycle is one *tick*, which is half a period of the test clock. A three-bit function-select input chooses one of several things for each group: the operating-point rates, a divided test-clock pattern, or a floating output state.

Per-output enable inputs take an output in or out of service without a glitch. A disabled output always completes its current high phase and then stays low. A re-enabled output starts again with a full-width high phase. An asynchronous active-low power-down input is synchronised and then sampled on host-clock rising events. It must be seen low on two such samples in a row before it stops every output, and each output stops on its own next falling edge. A further input raises the memory group to the fast rate, but only at the operating point where the host runs fast and memory runs slow.

Top module: `clkgen_top`

## Requirements
- R1: `oe_o` is a registered output. One tick after `fsel_i[1:0]` is 2'b00 it is 0, whatever the value of `fsel_i[2]`. One tick after any other code it is 1.
- R2: With `fsel_i[1:0]` = 2'b01 (test mode), the periods in ticks are as follows: host, memory and 48 MHz outputs 4; hub outputs 6; peripheral and interrupt-controller outputs 12; reference output 2.
- R3: The operating-point half-periods in ticks (defaults in brackets) are set by the `fsel_i` code. Code 3'b010 gives host HP_66 (6) and memory HP_100 (4). Code 3'b011 gives host HP_100 and memory HP_100. Code 3'b110 gives host HP_133 (3) and memory HP_133. Code 3'b111 gives host HP_133 and memory HP_100. In all four codes the hub half-period is HP_66, peripheral and interrupt-controller HP_33 (12), 48 MHz HP_48 (8) and reference HP_REF (28).
- R4: When an enable input is 0, its output finishes any high phase in progress and then stays low without switching.
- R5: When an enable input returns to 1, its output rises only at its group's own rising edge. Each high phase lasts the full half-period, so a host output that rises is still high on the next tick.
- R6: The enable inputs cannot stop `sdram_free_o`, `pci_free_o`, `cpu_o[1:0]`, `hub_o[1:0]`, `apic_o` or `ref_o`. Only power-down stops them.
- R7: `pwrdn_ni` passes through two flops that are clocked on host-clock rising events. Power-down takes effect only after two consecutive such synchronised samples are low. A low pulse that covers one host rising event has no effect. Once power-down is in effect, every output settles low on its own next falling edge and stays low, and `osc_run_o` and `pll_run_o` are 0.
- R8: One synchronised high sample ends power-down. `osc_run_o` and `pll_run_o` return to 1, and each output resumes with a full high phase.
- R9: `sdram_fast_i` = 1 changes the memory half-period from HP_100 to HP_133 only for code 3'b111. The host and other groups keep their waveform across the change.
- R10: While `rst_ni` is low, all clock outputs and `oe_o` are 0 and `osc_run_o` and `pll_run_o` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Tick clock, twice the test-clock rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fsel_i | input | 3 | Function select: float, test or operating point |
| sdram_fast_i | input | 1 | Request the fast memory rate |
| pwrdn_ni | input | 1 | Asynchronous active-low power-down request |
| en_cpu2_i | input | 1 | Enable for host output 2 |
| en_usb_i | input | 2 | Enables for the 48 MHz outputs |
| en_sdram_i | input | 8 | Enables for the switchable memory outputs |
| en_agp_i | input | 1 | Enable for hub output 2 |
| en_pci_i | input | 6 | Enables for the switchable peripheral outputs |
| cpu_o | output | 3 | Host clocks |
| sdram_o | output | 8 | Switchable memory clocks |
| sdram_free_o | output | 1 | Free-running memory clock |
| hub_o | output | 3 | Hub clocks |
| pci_o | output | 6 | Switchable peripheral clocks |
| pci_free_o | output | 1 | Free-running peripheral clock |
| apic_o | output | 2 | Interrupt-controller clocks |
| usb_o | output | 2 | 48 MHz clocks |
| ref_o | output | 1 | Reference clock |
| oe_o | output | 1 | Output-drive enable; 0 means all clock pins float |
| osc_run_o | output | 1 | Oscillator run indication |
| pll_run_o | output | 1 | Frequency-synthesiser run indication |

## Verification
The properties assume that `fsel_i`, `sdram_fast_i` and the enable inputs are synchronous to `clk_i` and change at most once per tick. They also assume that reset is held from time zero. The stop-low properties need an enable, or the power-down state, that has been stable for two ticks. The stimulus drives every input on the falling edge of `clk_i`. It changes the function select only while no power-down is pending, and it waits for all groups to settle before it counts edges. The power-down glitch is made shorter than one host period, so it can cover at most one sampling event.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;

    localparam int N_GRP = 7;
    localparam int N_OUT = 27;

    localparam int G_CPU  = 0;
    localparam int G_SDR  = 1;
    localparam int G_HUB  = 2;
    localparam int G_PCI  = 3;
    localparam int G_APIC = 4;
    localparam int G_USB  = 5;
    localparam int G_REF  = 6;

    typedef enum logic [2:0] {
        M_FLOAT,
        M_TEST,
        M_66_100,
        M_100_100,
        M_133_133,
        M_133_100
    } mode_e;

    function automatic mode_e decode_mode(input logic [2:0] fs, input logic fast);
        mode_e m;
        unique case (fs[1:0])
            2'b00:   m = M_FLOAT;
            2'b01:   m = M_TEST;
            2'b10:   m = fs[2] ? M_133_133 : M_66_100;
            default: m = fs[2] ? (fast ? M_133_133 : M_133_100) : M_100_100;
        endcase
        return m;
    endfunction

    // Output vector layout: host, memory, memory-free, hub, peripheral,
    // peripheral-free, interrupt controller, 48 MHz, reference.
    function automatic int grp_of(input int i);
        if (i < 3)  return G_CPU;
        if (i < 12) return G_SDR;
        if (i < 15) return G_HUB;
        if (i < 22) return G_PCI;
        if (i < 24) return G_APIC;
        if (i < 26) return G_USB;
        return G_REF;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/clkgen_div.sv
module clkgen_div #(
    parameter int HPW = 5
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic [HPW-1:0] hp_i,
    output logic           lvl_nxt_o
);
    typedef struct packed {
        logic [HPW-1:0] cnt;
        logic           lvl;
    } div_st_t;

    div_st_t       div_d, div_q;
    logic          tog;
    logic [HPW:0]  cnt_inc;

    always_comb begin
        cnt_inc   = {1'b0, div_q.cnt} + (HPW+1)'(1);
        tog       = (cnt_inc >= {1'b0, hp_i});
        div_d.cnt = tog ? '0 : cnt_inc[HPW-1:0];
        div_d.lvl = div_q.lvl ^ tog;
        lvl_nxt_o = div_d.lvl;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) div_q <= '0;
        else         div_q <= div_d;
    end
endmodule

// File: rtl/clkgen_pdctl.sv
module clkgen_pdctl #(
    parameter int SAMPLES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic sample_i,
    input  logic pwrdn_ni,
    output logic pd_o
);
    localparam int CW = $clog2(SAMPLES + 1);

    typedef struct packed {
        logic          s1;
        logic          s2;
        logic [CW-1:0] cnt;
        logic          pd;
    } pd_st_t;

    pd_st_t pd_d, pd_q;

    always_comb begin
        pd_d = pd_q;
        if (sample_i) begin
            pd_d.s1 = pwrdn_ni;
            pd_d.s2 = pd_q.s1;
            if (pd_q.s2)
                pd_d.cnt = '0;
            else if (pd_q.cnt != CW'(SAMPLES))
                pd_d.cnt = pd_q.cnt + CW'(1);
            pd_d.pd = (pd_d.cnt == CW'(SAMPLES));
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pd_q <= '{s1: 1'b1, s2: 1'b1, cnt: '0, pd: 1'b0};
        else         pd_q <= pd_d;
    end

    assign pd_o = pd_q.pd;
endmodule

// File: rtl/clkgen_gate.sv
module clkgen_gate #(
    parameter int N = 27
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [N-1:0] nxt_i,
    input  logic [N-1:0] en_i,
    output logic [N-1:0] clk_o
);
    typedef struct packed {
        logic [N-1:0] run;
        logic [N-1:0] out;
    } gate_st_t;

    gate_st_t gate_d, gate_q;

    // The run flag may only change while the source level is low, so a
    // stop lands on a falling edge and a start waits for a full rising phase.
    always_comb begin
        gate_d.run = (nxt_i & gate_q.run) | (~nxt_i & en_i);
        gate_d.out = nxt_i & gate_d.run;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) gate_q <= '0;
        else         gate_q <= gate_d;
    end

    assign clk_o = gate_q.out;
endmodule

// File: rtl/clkgen_top.sv
module clkgen_top
    import clkgen_pkg::*;
#(
    parameter int HP_133     = 3,
    parameter int HP_100     = 4,
    parameter int HP_66      = 6,
    parameter int HP_33      = 12,
    parameter int HP_48      = 8,
    parameter int HP_REF     = 28,
    parameter int PD_SAMPLES = 2
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic [2:0] fsel_i,
    input  logic       sdram_fast_i,
    input  logic       pwrdn_ni,
    input  logic       en_cpu2_i,
    input  logic [1:0] en_usb_i,
    input  logic [7:0] en_sdram_i,
    input  logic       en_agp_i,
    input  logic [5:0] en_pci_i,
    output logic [2:0] cpu_o,
    output logic [7:0] sdram_o,
    output logic       sdram_free_o,
    output logic [2:0] hub_o,
    output logic [5:0] pci_o,
    output logic       pci_free_o,
    output logic [1:0] apic_o,
    output logic [1:0] usb_o,
    output logic       ref_o,
    output logic       oe_o,
    output logic       osc_run_o,
    output logic       pll_run_o
);
    localparam int HP_MAX = imax(imax(imax(HP_133, HP_100), imax(HP_66, HP_33)),
                                 imax(imax(HP_48, HP_REF), 6));
    localparam int HPW    = $clog2(HP_MAX + 1);

    typedef struct packed {
        logic oe;
        logic cpu_lvl;
    } top_st_t;

    top_st_t          top_d, top_q;
    mode_e            mode;
    logic [HPW-1:0]   hp [N_GRP];
    logic [N_GRP-1:0] grp_nxt;
    logic [N_OUT-1:0] out_nxt, en_vec, en_eff, clk_vec;
    logic             cpu_rise, pd;

    always_comb begin
        mode = decode_mode(fsel_i, sdram_fast_i);
        if (mode == M_FLOAT || mode == M_TEST) begin
            hp[G_CPU]  = HPW'(2);
            hp[G_SDR]  = HPW'(2);
            hp[G_HUB]  = HPW'(3);
            hp[G_PCI]  = HPW'(6);
            hp[G_APIC] = HPW'(6);
            hp[G_USB]  = HPW'(2);
            hp[G_REF]  = HPW'(1);
        end else begin
            unique case (mode)
                M_66_100:  begin hp[G_CPU] = HPW'(HP_66);  hp[G_SDR] = HPW'(HP_100); end
                M_100_100: begin hp[G_CPU] = HPW'(HP_100); hp[G_SDR] = HPW'(HP_100); end
                M_133_133: begin hp[G_CPU] = HPW'(HP_133); hp[G_SDR] = HPW'(HP_133); end
                default:   begin hp[G_CPU] = HPW'(HP_133); hp[G_SDR] = HPW'(HP_100); end
            endcase
            hp[G_HUB]  = HPW'(HP_66);
            hp[G_PCI]  = HPW'(HP_33);
            hp[G_APIC] = HPW'(HP_33);
            hp[G_USB]  = HPW'(HP_48);
            hp[G_REF]  = HPW'(HP_REF);
        end
    end

    for (genvar g = 0; g < N_GRP; g++) begin : g_div
        clkgen_div #(.HPW(HPW)) u_div (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .hp_i      (hp[g]),
            .lvl_nxt_o (grp_nxt[g])
        );
    end

    for (genvar i = 0; i < N_OUT; i++) begin : g_fan
        localparam int GI = grp_of(i);
        assign out_nxt[i] = grp_nxt[GI];
    end

    always_comb begin
        top_d.oe      = (fsel_i[1:0] != 2'b00);
        top_d.cpu_lvl = grp_nxt[G_CPU];
        cpu_rise      = grp_nxt[G_CPU] & ~top_q.cpu_lvl;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) top_q <= '0;
        else         top_q <= top_d;
    end

    clkgen_pdctl #(.SAMPLES(PD_SAMPLES)) u_pd (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .sample_i (cpu_rise),
        .pwrdn_ni (pwrdn_ni),
        .pd_o     (pd)
    );

    assign en_vec = {1'b1, en_usb_i, 2'b11, 1'b1, en_pci_i, en_agp_i, 2'b11,
                     1'b1, en_sdram_i, en_cpu2_i, 2'b11};
    assign en_eff = en_vec & ~{N_OUT{pd}};

    clkgen_gate #(.N(N_OUT)) u_gate (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .nxt_i  (out_nxt),
        .en_i   (en_eff),
        .clk_o  (clk_vec)
    );

    assign {ref_o, usb_o, apic_o, pci_free_o, pci_o, hub_o,
            sdram_free_o, sdram_o, cpu_o} = clk_vec;
    assign oe_o      = top_q.oe;
    assign osc_run_o = ~pd;
    assign pll_run_o = ~pd;
endmodule

// File: rtl/clkgen_chk.sv
module clkgen_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic [2:0] fsel_i,
    input logic       en_sdram0_i,
    input logic       sdram0_i,
    input logic       cpu2_i,
    input logic       sdram_free_i,
    input logic       osc_run_i,
    input logic       oe_i
);
    // R1: float code reaches the drive enable one tick later
    a_r1_float_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fsel_i[1:0] == 2'b00) |=> !oe_i);

    // R4: a disabled output that is low stays low
    a_r4_stop_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!en_sdram0_i && $past(!en_sdram0_i) && !sdram0_i) |=> !sdram0_i);

    // R5: a host high phase is never a one-tick runt
    a_r5_no_runt: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(cpu2_i) |=> cpu2_i);

    // R7: in power-down the free-running memory clock stays low once low
    a_r7_pd_hold_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!osc_run_i && $past(!osc_run_i) && !sdram_free_i) |=> !sdram_free_i);
endmodule

bind clkgen_top clkgen_chk chk_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fsel_i       (fsel_i),
    .en_sdram0_i  (en_sdram_i[0]),
    .sdram0_i     (sdram_o[0]),
    .cpu2_i       (cpu_o[2]),
    .sdram_free_i (sdram_free_o),
    .osc_run_i    (osc_run_o),
    .oe_i         (oe_o)
);

// File: tb/clkgen_top_tb_top.sv
module clkgen_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] fsel = 3'b001;
    logic       fast = 1'b0;
    logic       pd_n = 1'b1;
    logic       en_cpu2 = 1'b1;
    logic [1:0] en_usb = 2'b11;
    logic [7:0] en_sdram = 8'hFF;
    logic       en_agp = 1'b1;
    logic [5:0] en_pci = 6'h3F;

    logic [2:0] cpu, hub;
    logic [7:0] sdram;
    logic [5:0] pci;
    logic [1:0] apic, usb;
    logic       sdram_free, pci_free, ref_clk, oe, osc_run, pll_run;
    logic [26:0] act_v;

    int    n_vec = 0, n_fail = 0;
    string cur_req = "R10";
    bit    done = 1'b0;

    // reference model state
    int mcnt [7];
    bit mlvl [7];
    bit mrun [27];
    bit mout [27];
    bit ms1, ms2, mpd, moe;
    int mpc;

    always #2 clk = ~clk;

    clkgen_top dut_i (
        .clk_i(clk), .rst_ni(rst_n), .fsel_i(fsel), .sdram_fast_i(fast),
        .pwrdn_ni(pd_n), .en_cpu2_i(en_cpu2), .en_usb_i(en_usb),
        .en_sdram_i(en_sdram), .en_agp_i(en_agp), .en_pci_i(en_pci),
        .cpu_o(cpu), .sdram_o(sdram), .sdram_free_o(sdram_free), .hub_o(hub),
        .pci_o(pci), .pci_free_o(pci_free), .apic_o(apic), .usb_o(usb),
        .ref_o(ref_clk), .oe_o(oe), .osc_run_o(osc_run), .pll_run_o(pll_run)
    );

    assign act_v = {ref_clk, usb, apic, pci_free, pci, hub, sdram_free, sdram, cpu};

    function automatic int bgrp(input int i);
        if (i <= 2)  return 0;
        if (i <= 11) return 1;
        if (i <= 14) return 2;
        if (i <= 21) return 3;
        if (i <= 23) return 4;
        if (i <= 25) return 5;
        return 6;
    endfunction

    function automatic int bhp(input int g, input logic [2:0] fs, input bit fst);
        int tst [7] = '{2, 2, 3, 6, 6, 2, 1};
        if (fs[1:0] == 2'b00 || fs[1:0] == 2'b01) return tst[g];
        case (g)
            0: return (fs == 3'b010) ? 6 : (fs == 3'b011) ? 4 : 3;
            1: return (fs == 3'b110 || (fs == 3'b111 && fst)) ? 3 : 4;
            2: return 6;
            3, 4: return 12;
            5: return 8;
            default: return 28;
        endcase
    endfunction

    function automatic bit en_bit(input int i);
        if (i == 2) return en_cpu2;
        if (i >= 3 && i <= 10) return en_sdram[i-3];
        if (i == 14) return en_agp;
        if (i >= 15 && i <= 20) return en_pci[i-15];
        if (i == 24 || i == 25) return en_usb[i-24];
        return 1'b1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int g = 0; g < 7; g++) begin mcnt[g] = 0; mlvl[g] = 0; end
            for (int i = 0; i < 27; i++) begin mrun[i] = 0; mout[i] = 0; end
            ms1 = 1; ms2 = 1; mpd = 0; mpc = 0; moe = 0;
        end else begin
            bit nx [7];
            bit cpu_up;
            bit pd_old;
            pd_old = mpd;
            cpu_up = 0;
            for (int g = 0; g < 7; g++) begin
                bit t;
                t = (mcnt[g] + 1 >= bhp(g, fsel, fast));
                if (g == 0) cpu_up = t && !mlvl[0];
                nx[g]   = mlvl[g] ^ t;
                mcnt[g] = t ? 0 : mcnt[g] + 1;
                mlvl[g] = nx[g];
            end
            for (int i = 0; i < 27; i++) begin
                if (!nx[bgrp(i)]) mrun[i] = en_bit(i) && !pd_old;
                mout[i] = nx[bgrp(i)] && mrun[i];
            end
            if (cpu_up) begin
                if (ms2) mpc = 0;
                else if (mpc < 2) mpc++;
                ms2 = ms1;
                ms1 = pd_n;
                mpd = (mpc == 2);
            end
            moe = (fsel[1:0] != 2'b00);
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            logic [26:0] ev;
            for (int i = 0; i < 27; i++) ev[i] = mout[i];
            chk(cur_req, "clock vector", int'(act_v), int'(ev));
            chk(cur_req, "oe", int'(oe), int'(moe));
            chk(cur_req, "osc_run", int'(osc_run), int'(!mpd));
            chk(cur_req, "pll_run", int'(pll_run), int'(!mpd));
        end
    end

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic count_rises(input int idx, input int n, output int cnt);
        bit prev;
        cnt  = 0;
        prev = act_v[idx];
        repeat (n) begin
            @(negedge clk);
            if (act_v[idx] && !prev) cnt++;
            prev = act_v[idx];
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        int n;
        // R10: reset state
        ticks(5);
        chk("R10", "clocks in reset", int'(act_v), 0);
        chk("R10", "oe in reset", int'(oe), 0);
        chk("R10", "osc_run in reset", int'(osc_run), 1);
        chk("R10", "pll_run in reset", int'(pll_run), 1);
        rst_n = 1'b1;

        // R2: test mode periods
        cur_req = "R2";
        ticks(30);
        count_rises(0, 48, n);  chk("R2", "host rises/48", n, 12);
        count_rises(3, 48, n);  chk("R2", "memory rises/48", n, 12);
        count_rises(12, 48, n); chk("R2", "hub rises/48", n, 8);
        count_rises(15, 48, n); chk("R2", "peripheral rises/48", n, 4);
        count_rises(22, 48, n); chk("R2", "apic rises/48", n, 4);
        count_rises(24, 48, n); chk("R2", "usb rises/48", n, 12);
        count_rises(26, 48, n); chk("R2", "ref rises/48", n, 24);

        // R1: float codes
        cur_req = "R1";
        fsel = 3'b000; ticks(3); chk("R1", "oe code 000", int'(oe), 0);
        fsel = 3'b100; ticks(3); chk("R1", "oe code 100", int'(oe), 0);
        fsel = 3'b011; ticks(3); chk("R1", "oe code 011", int'(oe), 1);

        // R3: operating points
        cur_req = "R3";
        ticks(40);
        count_rises(0, 48, n);  chk("R3", "host 011", n, 6);
        count_rises(26, 56, n); chk("R3", "ref 011", n, 1);
        fsel = 3'b010; ticks(40);
        count_rises(0, 48, n);  chk("R3", "host 010", n, 4);
        count_rises(3, 48, n);  chk("R3", "memory 010", n, 6);
        fsel = 3'b110; ticks(40);
        count_rises(0, 48, n);  chk("R3", "host 110", n, 8);
        count_rises(3, 48, n);  chk("R3", "memory 110", n, 8);

        // R9: fast memory request
        cur_req = "R9";
        fsel = 3'b111; ticks(40);
        count_rises(11, 48, n); chk("R9", "memory 111 slow", n, 6);
        fast = 1'b1; ticks(40);
        count_rises(11, 48, n); chk("R9", "memory 111 fast", n, 8);
        count_rises(0, 48, n);  chk("R9", "host 111 fast", n, 8);
        fsel = 3'b011; ticks(40);
        count_rises(11, 48, n); chk("R9", "memory 011 fast ignored", n, 6);
        fast = 1'b0;

        // R4 and R6: disable switchable outputs
        cur_req = "R4";
        en_sdram = 8'h00; en_pci = 6'h00; en_cpu2 = 1'b0; en_agp = 1'b0; en_usb = 2'b00;
        ticks(30);
        count_rises(3, 48, n);  chk("R4", "disabled memory rises", n, 0);
        count_rises(2, 48, n);  chk("R4", "disabled host2 rises", n, 0);
        chk("R4", "disabled outputs low", int'({sdram, pci, usb, cpu[2], hub[2]}), 0);
        cur_req = "R6";
        count_rises(11, 48, n); chk("R6", "memory free rises", n, 6);
        count_rises(21, 48, n); chk("R6", "peripheral free rises", n, 2);
        count_rises(0, 48, n);  chk("R6", "host0 rises", n, 6);

        // R5: re-enable
        cur_req = "R5";
        en_sdram = 8'hFF; en_pci = 6'h3F; en_cpu2 = 1'b1; en_agp = 1'b1; en_usb = 2'b11;
        ticks(30);
        count_rises(3, 48, n);  chk("R5", "memory resumes", n, 6);
        count_rises(2, 48, n);  chk("R5", "host2 resumes", n, 6);

        // R7: glitch shorter than one host period is ignored
        cur_req = "R7";
        pd_n = 1'b0; ticks(6); pd_n = 1'b1;
        n = 1;
        for (int k = 0; k < 60; k++) begin
            @(negedge clk);
            if (!osc_run) n = 0;
        end
        chk("R7", "osc_run after glitch", n, 1);

        // R7: real power-down
        pd_n = 1'b0; ticks(120);
        chk("R7", "clocks in power-down", int'(act_v), 0);
        chk("R7", "osc_run in power-down", int'(osc_run), 0);
        chk("R7", "pll_run in power-down", int'(pll_run), 0);
        count_rises(11, 48, n); chk("R7", "memory free stopped", n, 0);

        // R8: release
        cur_req = "R8";
        pd_n = 1'b1; ticks(60);
        chk("R8", "osc_run after release", int'(osc_run), 1);
        count_rises(0, 48, n);  chk("R8", "host after release", n, 6);
        count_rises(21, 48, n); chk("R8", "peripheral free after release", n, 2);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule